// File: doc/BRIEF.md
# Dual-Issue Pair Dispatch Checker

This block decides, each cycle, whether the instruction decoded for the secondary pipeline may issue together with the instruction held in the primary pipeline. It takes pre-decoded descriptor fields from both slots and gives a separate verdict for each of three pairing rules. The first rule covers addressing modes that the secondary address unit cannot build. The second covers the single operand-cache port the two pipelines share. The third covers base or index registers that the primary instruction is still producing. The three verdicts, together with a secondary-valid input, form the dual-issue grant. When the grant is low, only the primary instruction issues.

The block also tracks a multi-cycle floating-point operation that allows overlap. While such an operation runs, integer pairs keep issuing normally. A second floating-point instruction in either slot raises a stall until the running one reports completion. A parameter selects whether the verdicts and the grant leave the block combinationally or through a one-cycle output register.

Register operands travel as 5-bit tagged names. The top bit marks a real register. The low four bits select it: 0 to 7 for data registers and 8 to 15 for address registers. So d0 is 16 and a0 is 24.

Top module: `pair_dispatch_chk`

## Requirements
- R1: Secondary mode class `s_mode` uses this encoding: 0 plain/register, 1 An indirect, 2 An with 16-bit displacement, 3 An with 8-bit displacement and index, 4 An with index and base displacement, 5 PC with 16-bit displacement, 6 PC with 8-bit displacement and index, 7 PC with index and base displacement. `test_ea_ok` is 0 for classes 4 to 7 and 1 for classes 0 to 3.
- R2: `test_mem_ok` is 0 exactly when `p_mem` and `s_mem` are both 1.
- R3: A resource name whose bit 4 is 0 is not a register and never causes a register conflict, even when it equals a primary result name.
- R4: If `s_base` has bit 4 set and equals `p_addr_res` or `p_exec_res`, `test_reg_ok` is 0.
- R5: If `s_index` has bit 4 set and equals `p_addr_res` or `p_exec_res`, `test_reg_ok` is 0. With no base or index conflict, `test_reg_ok` is 1.
- R6: `dual_grant` equals `s_valid` AND `test_ea_ok` AND `test_mem_ok` AND `test_reg_ok`.
- R7: A primary floating-point instruction (`p_fp`=1) with `p_fp_ovl`=1 that is not stalled sets an internal busy state at the clock edge. A primary floating-point instruction with `p_fp_ovl`=0 does not. While busy, `fp_stall` is 1 whenever `p_fp` or `s_fp` is 1.
- R8: `fp_done` clears busy at the next clock edge, so `fp_stall` stays 1 in the `fp_done` cycle itself. An overlap issue in the same cycle as `fp_done` takes priority and leaves busy set.
- R9: While busy, integer-only pairs (`p_fp`=`s_fp`=0) see `fp_stall`=0, and their `dual_grant` follows R6 unchanged.
- R10: After synchronous reset, busy is clear, so `fp_stall` is 0 even with floating-point instructions present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Secondary slot holds an instruction |
| s_mode | input | 3 | Secondary addressing-mode class |
| p_mem | input | 1 | Primary references operand memory |
| s_mem | input | 1 | Secondary references operand memory |
| s_base | input | 5 | Secondary base resource name (tagged) |
| s_index | input | 5 | Secondary index resource name (tagged) |
| p_addr_res | input | 5 | Primary address-result destination (tagged) |
| p_exec_res | input | 5 | Primary execute-result destination (tagged) |
| p_fp | input | 1 | Primary is a floating-point instruction |
| p_fp_ovl | input | 1 | Primary floating-point instruction allows overlap |
| s_fp | input | 1 | Secondary is a floating-point instruction |
| fp_done | input | 1 | Running floating-point operation completes |
| test_ea_ok | output | 1 | Addressing-mode test passes |
| test_mem_ok | output | 1 | Memory-port test passes |
| test_reg_ok | output | 1 | Register-conflict test passes |
| dual_grant | output | 1 | Secondary may issue with primary |
| fp_stall | output | 1 | Dispatch stall for floating-point overlap |

## Verification
The pairing verdict and the floating-point stall can both act in the same cycle, and they must not affect each other. The bench starts an overlap-class operation and then presents integer pairs while busy. Some pairs conflict and some do not. It checks that each grant matches the pairing rules and that the stall stays low. It then adds a floating-point instruction in the secondary slot and requires the stall to rise while the pairing verdict is unchanged. It also drives completion and a new issue in the same cycle and judges the busy state through the stall output on the following cycle.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    localparam int RES_W     = 5;
    localparam int REG_SEL_W = RES_W - 1;
    localparam int AM_W      = 3;

    typedef logic [RES_W-1:0] res_name_t;

    typedef enum logic [AM_W-1:0] {
        AM_PLAIN       = 3'd0,
        AM_AREG_IND    = 3'd1,
        AM_AREG_D16    = 3'd2,
        AM_AREG_IDX8   = 3'd3,
        AM_AREG_IDX_BD = 3'd4,
        AM_PC_D16      = 3'd5,
        AM_PC_IDX8     = 3'd6,
        AM_PC_IDX_BD   = 3'd7
    } am_class_e;

    typedef struct packed {
        logic ea_ok;
        logic mem_ok;
        logic reg_ok;
        logic grant;
    } pair_verdict_t;

    function automatic logic res_is_reg(res_name_t n);
        return n[RES_W-1];
    endfunction

    function automatic logic am_fits_secondary(am_class_e m);
        logic ok;
        case (m)
            AM_PLAIN, AM_AREG_IND, AM_AREG_D16, AM_AREG_IDX8: ok = 1'b1;
            default:                                          ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic res_collides(res_name_t src, res_name_t dst_a, res_name_t dst_b);
        return res_is_reg(src) && ((src == dst_a) || (src == dst_b));
    endfunction

endpackage

// File: rtl/dsp_ea_test.sv
module dsp_ea_test
    import dispatch_pkg::*;
(
    input  logic [AM_W-1:0] mode,
    output logic            ea_ok
);
    am_class_e mode_cls;

    always_comb begin
        mode_cls = am_class_e'(mode);
        ea_ok    = am_fits_secondary(mode_cls);
    end
endmodule

// File: rtl/dsp_mem_test.sv
module dsp_mem_test #(
    parameter int PORTS = 1
) (
    input  logic prim_mem,
    input  logic sec_mem,
    output logic mem_ok
);
    localparam int CNT_W = 2;
    logic [CNT_W-1:0] refs;

    always_comb begin
        refs   = CNT_W'(prim_mem) + CNT_W'(sec_mem);
        mem_ok = (refs <= CNT_W'(PORTS));
    end
endmodule

// File: rtl/dsp_reg_hazard.sv
module dsp_reg_hazard
    import dispatch_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC*RES_W-1:0] src_names,
    input  res_name_t                dst_addr,
    input  res_name_t                dst_exec,
    output logic                     reg_ok
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        res_name_t name_i;
        assign name_i = src_names[i*RES_W +: RES_W];
        assign hit[i] = res_collides(name_i, dst_addr, dst_exec);
    end

    assign reg_ok = ~|hit;
endmodule

// File: rtl/dsp_fp_overlap.sv
module dsp_fp_overlap (
    input  logic clk,
    input  logic rst,
    input  logic prim_fp,
    input  logic prim_ovl,
    input  logic sec_fp,
    input  logic done,
    output logic stall
);
    logic busy_q;
    logic start;

    always_comb begin
        stall = busy_q && (prim_fp || sec_fp);
        start = prim_fp && prim_ovl && !stall;
    end

    always_ff @(posedge clk) begin
        if (rst)        busy_q <= 1'b0;
        else if (start) busy_q <= 1'b1;
        else if (done)  busy_q <= 1'b0;
    end
endmodule

// File: rtl/pair_dispatch_chk.sv
module pair_dispatch_chk
    import dispatch_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       s_valid,
    input  logic [2:0] s_mode,
    input  logic       p_mem,
    input  logic       s_mem,
    input  logic [4:0] s_base,
    input  logic [4:0] s_index,
    input  logic [4:0] p_addr_res,
    input  logic [4:0] p_exec_res,
    input  logic       p_fp,
    input  logic       p_fp_ovl,
    input  logic       s_fp,
    input  logic       fp_done,
    output logic       test_ea_ok,
    output logic       test_mem_ok,
    output logic       test_reg_ok,
    output logic       dual_grant,
    output logic       fp_stall
);
    localparam int NUM_SRC = 2;

    logic          ea_ok_c, mem_ok_c, reg_ok_c;
    pair_verdict_t verdict_c, verdict_o;

    dsp_ea_test u_ea (
        .mode  (s_mode),
        .ea_ok (ea_ok_c)
    );

    dsp_mem_test #(.PORTS(1)) u_mem (
        .prim_mem (p_mem),
        .sec_mem  (s_mem),
        .mem_ok   (mem_ok_c)
    );

    dsp_reg_hazard #(.NUM_SRC(NUM_SRC)) u_haz (
        .src_names ({s_index, s_base}),
        .dst_addr  (p_addr_res),
        .dst_exec  (p_exec_res),
        .reg_ok    (reg_ok_c)
    );

    dsp_fp_overlap u_fp (
        .clk      (clk),
        .rst      (rst),
        .prim_fp  (p_fp),
        .prim_ovl (p_fp_ovl),
        .sec_fp   (s_fp),
        .done     (fp_done),
        .stall    (fp_stall)
    );

    always_comb begin
        verdict_c.ea_ok  = ea_ok_c;
        verdict_c.mem_ok = mem_ok_c;
        verdict_c.reg_ok = reg_ok_c;
        verdict_c.grant  = s_valid && ea_ok_c && mem_ok_c && reg_ok_c;
    end

    if (REG_OUT) begin : g_reg_out
        always_ff @(posedge clk) begin
            if (rst) verdict_o <= '0;
            else     verdict_o <= verdict_c;
        end
    end else begin : g_comb_out
        assign verdict_o = verdict_c;
    end

    assign test_ea_ok  = verdict_o.ea_ok;
    assign test_mem_ok = verdict_o.mem_ok;
    assign test_reg_ok = verdict_o.reg_ok;
    assign dual_grant  = verdict_o.grant;
endmodule

// File: rtl/pair_dispatch_chk_sva.sv
module pair_dispatch_chk_sva #(
    parameter bit REG_OUT = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       s_valid,
    input logic [2:0] s_mode,
    input logic       p_mem,
    input logic       s_mem,
    input logic [4:0] s_base,
    input logic [4:0] s_index,
    input logic [4:0] p_addr_res,
    input logic [4:0] p_exec_res,
    input logic       p_fp,
    input logic       p_fp_ovl,
    input logic       s_fp,
    input logic       fp_done,
    input logic       test_ea_ok,
    input logic       test_mem_ok,
    input logic       test_reg_ok,
    input logic       dual_grant,
    input logic       fp_stall
);
    if (REG_OUT == 1'b0) begin : g_comb
        AST_WIDE_MODE_REFUSED: assert property (@(posedge clk) disable iff (rst)
            (s_mode >= 3'd4) |-> !test_ea_ok); // R1
        AST_TWO_MEM_REFUSED: assert property (@(posedge clk) disable iff (rst)
            (p_mem && s_mem) |-> !test_mem_ok); // R2
        AST_BASE_HAZARD: assert property (@(posedge clk) disable iff (rst)
            (s_base[4] && (s_base == p_addr_res || s_base == p_exec_res)) |-> !test_reg_ok); // R4
        AST_INDEX_HAZARD: assert property (@(posedge clk) disable iff (rst)
            (s_index[4] && (s_index == p_addr_res || s_index == p_exec_res)) |-> !test_reg_ok); // R5
        AST_NO_SECONDARY_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
            !s_valid |-> !dual_grant); // R6
    end else begin : g_reg
        AST_WIDE_MODE_REFUSED: assert property (@(posedge clk) disable iff (rst)
            (s_mode >= 3'd4) |=> !test_ea_ok); // R1
        AST_TWO_MEM_REFUSED: assert property (@(posedge clk) disable iff (rst)
            (p_mem && s_mem) |=> !test_mem_ok); // R2
        AST_BASE_HAZARD: assert property (@(posedge clk) disable iff (rst)
            (s_base[4] && (s_base == p_addr_res || s_base == p_exec_res)) |=> !test_reg_ok); // R4
        AST_INDEX_HAZARD: assert property (@(posedge clk) disable iff (rst)
            (s_index[4] && (s_index == p_addr_res || s_index == p_exec_res)) |=> !test_reg_ok); // R5
        AST_NO_SECONDARY_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
            !s_valid |=> !dual_grant); // R6
    end

    AST_GRANT_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        dual_grant |-> (test_ea_ok && test_mem_ok && test_reg_ok)); // R6
    AST_STALL_NEEDS_FP: assert property (@(posedge clk) disable iff (rst)
        fp_stall |-> (p_fp || s_fp)); // R9
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (p_fp && p_fp_ovl && !fp_stall) ##1 (p_fp || s_fp) |-> fp_stall); // R7
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (fp_done && !(p_fp && p_fp_ovl && !fp_stall)) |=> !fp_stall); // R8
endmodule

bind pair_dispatch_chk pair_dispatch_chk_sva #(.REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/pair_dispatch_chk_tb.sv
module pair_dispatch_chk_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       s_valid, p_mem, s_mem, p_fp, p_fp_ovl, s_fp, fp_done;
    logic [2:0] s_mode;
    logic [4:0] s_base, s_index, p_addr_res, p_exec_res;
    logic       test_ea_ok, test_mem_ok, test_reg_ok, dual_grant, fp_stall;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [4:0] D0 = 5'd16, D1 = 5'd17, A0 = 5'd24, A1 = 5'd25, NONE = 5'd0;

    always #5 clk = ~clk;

    pair_dispatch_chk u_dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        s_valid = 1'b1; s_mode = 3'd0; p_mem = 1'b0; s_mem = 1'b0;
        s_base = NONE; s_index = NONE; p_addr_res = NONE; p_exec_res = NONE;
        p_fp = 1'b0; p_fp_ovl = 1'b0; s_fp = 1'b0; fp_done = 1'b0;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; idle();
        p_fp = 1'b1; s_fp = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        p_fp = 1'b0;
        settle();
        chk("R10 stall after reset", fp_stall, 1'b0);
        idle();
    endtask

    task automatic t_addr_base();
        @(negedge clk); idle();
        p_exec_res = A0; s_mode = 3'd1; s_base = A0; s_mem = 1'b1;
        settle();
        chk("R4 base vs exec result", test_reg_ok, 1'b0);
        chk("R6 grant on base hazard", dual_grant, 1'b0);
        p_exec_res = NONE; p_addr_res = A1; s_base = A1;
        settle();
        chk("R4 base vs addr result", test_reg_ok, 1'b0);
    endtask

    task automatic t_data_index();
        @(negedge clk); idle();
        p_exec_res = D0; s_mode = 3'd3; s_base = A1; s_index = D0;
        settle();
        chk("R5 index vs exec result", test_reg_ok, 1'b0);
        chk("R6 grant on index hazard", dual_grant, 1'b0);
    endtask

    task automatic t_independent();
        @(negedge clk); idle();
        p_exec_res = D0; s_mode = 3'd0; s_base = NONE; s_index = NONE;
        settle();
        chk("R5 independent pair reg ok", test_reg_ok, 1'b1);
        chk("R6 independent pair grant", dual_grant, 1'b1);
        s_valid = 1'b0;
        settle();
        chk("R6 no secondary no grant", dual_grant, 1'b0);
    endtask

    task automatic t_two_mem();
        @(negedge clk); idle();
        p_mem = 1'b1; s_mem = 1'b1;
        settle();
        chk("R2 both memory", test_mem_ok, 1'b0);
        chk("R6 grant both memory", dual_grant, 1'b0);
        s_mem = 1'b0;
        settle();
        chk("R2 one memory", test_mem_ok, 1'b1);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 8; m++) begin
            @(negedge clk); idle();
            s_mode = 3'(m);
            settle();
            chk($sformatf("R1 mode %0d", m), test_ea_ok, (m < 4) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic t_untagged();
        @(negedge clk); idle();
        s_base = 5'd8; s_index = 5'd0; p_exec_res = 5'd8; p_addr_res = 5'd0;
        settle();
        chk("R3 untagged names no conflict", test_reg_ok, 1'b1);
    endtask

    task automatic t_fp_overlap();
        @(negedge clk); idle();
        p_fp = 1'b1; p_fp_ovl = 1'b0;
        settle();
        chk("R7 non-overlap fp no stall", fp_stall, 1'b0);
        @(negedge clk); idle();
        s_fp = 1'b1;
        settle();
        chk("R7 non-overlap fp leaves idle", fp_stall, 1'b0);
        @(negedge clk); idle();
        p_fp = 1'b1; p_fp_ovl = 1'b1;
        settle();
        chk("R7 first fp not stalled", fp_stall, 1'b0);
        @(negedge clk); idle();
        p_exec_res = D1; s_base = A0;
        settle();
        chk("R9 int pair no stall while busy", fp_stall, 1'b0);
        chk("R9 int pair granted while busy", dual_grant, 1'b1);
        p_exec_res = A0;
        settle();
        chk("R9 hazard pair refused while busy", dual_grant, 1'b0);
        @(negedge clk); idle();
        s_fp = 1'b1;
        settle();
        chk("R7 second fp in secondary stalls", fp_stall, 1'b1);
        chk("R9 grant unaffected by stall", dual_grant, 1'b1);
        fp_done = 1'b1;
        settle();
        chk("R8 stall holds in done cycle", fp_stall, 1'b1);
        @(negedge clk);
        fp_done = 1'b0;
        settle();
        chk("R8 cleared after done", fp_stall, 1'b0);
        @(negedge clk); idle();
        p_fp = 1'b1; p_fp_ovl = 1'b1; fp_done = 1'b1;
        settle();
        chk("R8 issue with done not stalled", fp_stall, 1'b0);
        @(negedge clk); idle();
        p_fp = 1'b1;
        settle();
        chk("R8 issue wins over done", fp_stall, 1'b1);
        fp_done = 1'b1; p_fp = 1'b0;
        @(negedge clk); idle();
        s_fp = 1'b1;
        settle();
        chk("R8 done releases", fp_stall, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        idle();
        t_reset();
        t_addr_base();
        t_data_index();
        t_independent();
        t_two_mem();
        t_modes();
        t_untagged();
        t_fp_overlap();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule